// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block is the digital control front end of a converter that samples all of its input channels at the same instant and then digitises them one at a time. A host sets up a mux configuration register through a series of write strobes. Each strobe carries a channel address and four control bits. The configuration covers an inhibit flag, a choice between converting one channel or the whole set, a differential pairing request and a bipolar range request.

A write with the inhibit flag clear starts a conversion. The block pulses a sample-all output, drives an active-low busy flag and issues one conversion request per selected channel to an external converter, from the lowest channel upward. The converter answers each request with a done pulse and a result, which the block stores in a small result memory. After the run the host reads the results with successive read strobes. The read pointer moves through the channels that the last run converted. Changes to range and input type reach the converter one run late.

Channels form adjacent pairs (0/1, 2/3, ...). In a differential pair only the positive channel is converted, and its result is stored at that channel's index.

Top module: `conv_sequencer`

## Requirements
- R1: After synchronous reset, busy_n is 1 and sample_all, conv_start and rd_data are 0. The configuration is all-channel, single-ended and unipolar for every pair, so the first run converts every channel with conv_diff = 0 and conv_bip = 0.
- R2: An accepted write latches the address as the channel pointer and decodes wr_data as follows: bit 3 inhibit, bit 2 single-channel, bit 1 differential for the addressed pair, bit 0 bipolar. With bit 3 = 1 no conversion starts and busy_n stays 1.
- R3: A write with bit 3 = 0 while idle raises sample_all for exactly one cycle and drives busy_n low, both in the cycle after the write. This happens in single-channel mode as well.
- R4: In all-channel mode, every channel of a single-ended pair and only the positive channel of a differential pair is requested, in strictly ascending channel order.
- R5: In single-channel mode only the channel at the pointer is requested, and busy_n then returns high.
- R6: busy_n rises in the cycle after the done pulse of the final channel, and stays low after every earlier done pulse. Each result is written to the result memory at its channel index.
- R7: A changed bipolar or differential setting first applies to the conversion after the next one. The run started by the changing write still uses the previous setting.
- R8: When both channels of a pair are written with bit 1 = 1, the channel written last becomes the positive input.
- R9: While pd is 1, writes change neither the configuration nor the read pointer and start no conversion. The configuration is kept when pd returns to 0.
- R10: Writes that arrive while busy_n is 0 are ignored.
- R11: rd_data shows the result at the read pointer one cycle after rd_en. After an all-channel run the pointer starts at the lowest converted channel and steps through the converted channels, wrapping around. After a single-channel run it starts at the converted channel and steps through every index.
- R12: An accepted write with bit 3 = 1 moves the read pointer to the written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd | input | 1 | Power-down; blocks writes |
| wr_en | input | 1 | Configuration write strobe (one cycle) |
| wr_addr | input | 3 | Channel address of the write |
| wr_data | input | 4 | Control bits: inhibit, single, differential, bipolar |
| rd_en | input | 1 | Result read strobe |
| rd_data | output | 12 | Result at the read pointer, registered |
| busy_n | output | 1 | Low while a conversion run is in progress |
| sample_all | output | 1 | One-cycle pulse sampling every channel |
| conv_start | output | 1 | Conversion request pulse to the converter |
| conv_ch | output | 3 | Channel of the current request |
| conv_diff | output | 1 | Current request is differential |
| conv_bip | output | 1 | Current request uses bipolar range |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 12 | Converter result |

## Verification
The bench targets the one-run latency of range and pairing changes. A design that applied them at once would report the new differential mask or bipolar flag on the run that the changing write started. It loads conflicting pairings and expects the later-written channel to be converted. A design using the first write would request channel 2 instead of 3. It also reads past the end of the converted list and checks the wrap to the lowest channel, and it checks that inhibited writes and writes made under power-down or during a run leave the read pointer and the run untouched. A design that let such a write through would start an extra run or read back the wrong channel.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_t;

  localparam int CFG_W   = 4;
  localparam int CFG_INH = 3;
  localparam int CFG_SGL = 2;
  localparam int CFG_DIF = 1;
  localparam int CFG_BIP = 0;
endpackage

// File: rtl/seqr_chan_scan.sv
// Finds the lowest set bit of a mask and the next set bit above a cursor
// (wrapping to the lowest when none lies above).
module seqr_chan_scan #(
  parameter int N_CH = 8,
  localparam int CW = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask,
  input  logic [CW-1:0]   cur,
  output logic [CW-1:0]   first,
  output logic [CW-1:0]   nxt,
  output logic            has_next
);
  always_comb begin
    first    = '0;
    nxt      = '0;
    has_next = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask[i]) first = CW'(i);
      if (mask[i] && (i > int'(cur))) begin
        nxt      = CW'(i);
        has_next = 1'b1;
      end
    end
    if (!has_next) nxt = first;
  end
endmodule

// File: rtl/seqr_cfg_reg.sv
// Mux configuration: pending copy written by the host, active copy used by
// the converter and refreshed at the end of each run.
module seqr_cfg_reg
  import seqr_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CW = $clog2(N_CH),
  localparam int NP = N_CH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             pd,
  input  logic [CW-1:0]    addr,
  input  logic [CFG_W-1:0] data,
  input  logic             commit,
  output logic [CW-1:0]    ptr,
  output logic             single,
  output logic [NP-1:0]    act_diff,
  output logic             act_bip,
  output logic [N_CH-1:0]  conv_mask
);
  logic [NP-1:0] pend_diff, pend_pos, act_pos;
  logic          pend_bip;
  logic          wr_acc;
  logic [CW-2:0] pair;

  assign wr_acc = we & ~pd;
  assign pair   = addr[CW-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      single    <= 1'b0;
      pend_diff <= '0;
      pend_pos  <= '0;
      pend_bip  <= 1'b0;
      act_diff  <= '0;
      act_pos   <= '0;
      act_bip   <= 1'b0;
    end else begin
      if (wr_acc) begin
        ptr             <= addr;
        single          <= data[CFG_SGL];
        pend_bip        <= data[CFG_BIP];
        pend_diff[pair] <= data[CFG_DIF];
        if (data[CFG_DIF]) pend_pos[pair] <= addr[0];
      end
      if (commit) begin
        act_diff <= pend_diff;
        act_pos  <= pend_pos;
        act_bip  <= pend_bip;
      end
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign conv_mask[2*k]   = ~act_diff[k] | ~act_pos[k];
    assign conv_mask[2*k+1] = ~act_diff[k] |  act_pos[k];
  end

  a_r9_pd_freeze: assert property (@(posedge clk) disable iff (rst)
    pd |=> ($stable(ptr) && $stable(single) && $stable(pend_diff)
            && $stable(pend_pos) && $stable(pend_bip)));

  a_r7_active_on_commit: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_diff) && $stable(act_pos) && $stable(act_bip)));
endmodule

// File: rtl/seqr_seq_ctrl.sv
// Run controller: sample pulse, busy flag and per-channel requests.
module seqr_seq_ctrl
  import seqr_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CW = $clog2(N_CH),
  localparam int NP = N_CH / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            single,
  input  logic [CW-1:0]   ptr,
  input  logic [N_CH-1:0] conv_mask,
  input  logic [NP-1:0]   act_diff,
  input  logic            conv_done,
  output logic            busy_n,
  output logic            sample,
  output logic            conv_start,
  output logic [CW-1:0]   conv_ch,
  output logic            conv_diff,
  output logic            fin,
  output logic            ram_we,
  output logic [CW-1:0]   first_ch
);
  seq_state_t    state;
  logic [CW-1:0] scan_first, scan_nxt;
  logic          scan_more, last;

  seqr_chan_scan #(.N_CH(N_CH)) u_scan (
    .mask    (conv_mask),
    .cur     (conv_ch),
    .first   (scan_first),
    .nxt     (scan_nxt),
    .has_next(scan_more)
  );

  assign first_ch = single ? ptr : scan_first;
  assign last     = single | ~scan_more;
  assign ram_we   = (state == ST_WAIT) & conv_done;
  assign fin      = ram_we & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy_n     <= 1'b1;
      sample     <= 1'b0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      conv_diff  <= 1'b0;
    end else begin
      sample     <= 1'b0;
      conv_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SAMPLE;
            sample <= 1'b1;
            busy_n <= 1'b0;
          end
        end
        ST_SAMPLE: begin
          conv_ch    <= first_ch;
          conv_diff  <= act_diff[first_ch[CW-1:1]];
          conv_start <= 1'b1;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (last) begin
              state  <= ST_IDLE;
              busy_n <= 1'b1;
            end else begin
              conv_ch    <= scan_nxt;
              conv_diff  <= act_diff[scan_nxt[CW-1:1]];
              conv_start <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r3_sample_with_busy: assert property (@(posedge clk) disable iff (rst)
    sample |-> $fell(busy_n));

  a_r3_sample_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sample |=> !sample);

  a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !last) |=> (conv_ch > $past(conv_ch)));

  a_r5_single_channel: assert property (@(posedge clk) disable iff (rst)
    (conv_start && single) |-> (conv_ch == ptr));

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    fin |=> busy_n);

  a_r6_request_in_run: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !busy_n);
endmodule

// File: rtl/seqr_result_ram.sv
// Result store: one write port, one registered read port.
module seqr_result_ram #(
  parameter int N_CH = 8,
  parameter int DW   = 12,
  localparam int CW  = $clog2(N_CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [CW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N_CH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import seqr_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int DW   = 12,
  localparam int CW  = $clog2(N_CH),
  localparam int NP  = N_CH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             busy_n,
  output logic             sample_all,
  output logic             conv_start,
  output logic [CW-1:0]    conv_ch,
  output logic             conv_diff,
  output logic             conv_bip,
  input  logic             conv_done,
  input  logic [DW-1:0]    conv_data
);
  logic            wr_ok, start, inh_set, fin, ram_we, single;
  logic [CW-1:0]   ptr, first_ch, rd_ptr, rd_first, rd_nxt;
  logic [NP-1:0]   act_diff;
  logic [N_CH-1:0] conv_mask, rd_mask;
  logic            rd_more;

  assign wr_ok   = wr_en & busy_n;
  assign start   = wr_ok & ~pd & ~wr_data[CFG_INH];
  assign inh_set = wr_ok & ~pd &  wr_data[CFG_INH];

  seqr_cfg_reg #(.N_CH(N_CH)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_ok),
    .pd       (pd),
    .addr     (wr_addr),
    .data     (wr_data),
    .commit   (fin),
    .ptr      (ptr),
    .single   (single),
    .act_diff (act_diff),
    .act_bip  (conv_bip),
    .conv_mask(conv_mask)
  );

  seqr_seq_ctrl #(.N_CH(N_CH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .single    (single),
    .ptr       (ptr),
    .conv_mask (conv_mask),
    .act_diff  (act_diff),
    .conv_done (conv_done),
    .busy_n    (busy_n),
    .sample    (sample_all),
    .conv_start(conv_start),
    .conv_ch   (conv_ch),
    .conv_diff (conv_diff),
    .fin       (fin),
    .ram_we    (ram_we),
    .first_ch  (first_ch)
  );

  seqr_result_ram #(.N_CH(N_CH), .DW(DW)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (ram_we),
    .waddr(conv_ch),
    .wdata(conv_data),
    .re   (rd_en),
    .raddr(rd_ptr),
    .rdata(rd_data)
  );

  seqr_chan_scan #(.N_CH(N_CH)) u_rd_scan (
    .mask    (rd_mask),
    .cur     (rd_ptr),
    .first   (rd_first),
    .nxt     (rd_nxt),
    .has_next(rd_more)
  );

  // Read pointer walks the channels converted by the last run.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      rd_mask <= '1;
    end else if (fin) begin
      rd_ptr  <= first_ch;
      rd_mask <= single ? '1 : conv_mask;
    end else if (inh_set) begin
      rd_ptr  <= wr_addr;
    end else if (rd_en) begin
      rd_ptr  <= rd_nxt;
    end
  end

  a_r2_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy_n && wr_en && !pd && wr_data[CFG_INH]) |=> (busy_n && !sample_all));

  a_r9_pd_no_start: assert property (@(posedge clk) disable iff (rst)
    (pd && busy_n) |=> busy_n);

  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (!busy_n && wr_en) |=> $stable(ptr));

  a_r12_inhibit_ptr: assert property (@(posedge clk) disable iff (rst)
    inh_set |=> (rd_ptr == $past(wr_addr)));

  a_r11_read_wrap: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !fin && !inh_set && !rd_more) |=> (rd_ptr == $past(rd_first)));
endmodule

// File: tb/tb_conv_sequencer.sv
`timescale 1ns/1ps
module tb_conv_sequencer;
  localparam int N_CH = 8;
  localparam int DW = 12;
  localparam int CW = 3;
  localparam int CONV_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd = 1'b0;
  logic wr_en = 1'b0;
  logic [CW-1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic busy_n, sample_all, conv_start, conv_diff, conv_bip;
  logic [CW-1:0] conv_ch;
  logic conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;

  always #2.5 clk = ~clk;

  conv_sequencer #(.N_CH(N_CH), .DW(DW)) dut (
    .clk(clk), .rst(rst), .pd(pd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .busy_n(busy_n),
    .sample_all(sample_all), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_diff(conv_diff), .conv_bip(conv_bip), .conv_done(conv_done),
    .conv_data(conv_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model and request log
  logic [7:0] log_mask = '0, log_dmask = '0;
  logic log_bip = 1'b0, order_bad = 1'b0;
  int log_cnt = 0, last_ch = 0, seq_no = 0, pend_cnt = 0;
  logic [CW-1:0] p_ch = '0;
  logic p_diff = 1'b0, p_bip = 1'b0;
  logic [DW-1:0] exp_ram [N_CH];

  task automatic clear_log();
    log_mask = '0; log_dmask = '0; log_bip = 1'b0;
    order_bad = 1'b0; log_cnt = 0; last_ch = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (conv_done) begin
        conv_done = 1'b0;
        // R6: busy released only after the last result
        chk("R6 busy_n after result", int'(busy_n), conv_start ? 0 : 1);
      end
      if (conv_start) begin
        if (log_cnt > 0 && int'(conv_ch) <= last_ch) order_bad = 1'b1;
        last_ch = int'(conv_ch);
        log_mask[conv_ch] = 1'b1;
        if (conv_diff) log_dmask[conv_ch] = 1'b1;
        log_bip = conv_bip;
        log_cnt++;
        p_ch = conv_ch; p_diff = conv_diff; p_bip = conv_bip;
        pend_cnt = CONV_LAT;
      end else if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          conv_data = {6'(seq_no), p_diff, p_bip, 1'b0, p_ch};
          exp_ram[p_ch] = conv_data;
          seq_no++;
          conv_done = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog: busy_n actual=%0d expected=1", busy_n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic do_write(input logic [CW-1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (!busy_n) @(negedge clk);
  endtask

  task automatic do_read(output logic [DW-1:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  // {addr, wr_data(inh,single,diff,bip), starts, req mask, diff mask, bip}
  localparam logic [24:0] VEC [9] = '{
    {3'd0, 4'b1000, 1'b0, 8'h00, 8'h00, 1'b0},  // R2 inhibited
    {3'd0, 4'b0000, 1'b1, 8'hFF, 8'h00, 1'b0},  // R1 defaults, R4
    {3'd2, 4'b1011, 1'b0, 8'h00, 8'h00, 1'b0},  // R2 pend pair1 diff, bip
    {3'd3, 4'b1011, 1'b0, 8'h00, 8'h00, 1'b0},  // R8 ch3 written last
    {3'd0, 4'b0001, 1'b1, 8'hFF, 8'h00, 1'b0},  // R7 old setting
    {3'd0, 4'b0001, 1'b1, 8'hFB, 8'h08, 1'b1},  // R7 new, R8 pos ch3
    {3'd5, 4'b0110, 1'b1, 8'h20, 8'h00, 1'b1},  // R5 single ch5
    {3'd4, 4'b0100, 1'b1, 8'h10, 8'h10, 1'b0},  // R5/R7 pair2 diff late
    {3'd0, 4'b0000, 1'b1, 8'hFB, 8'h08, 1'b0}   // R4 skip ch2
  };

  localparam int RD_ORDER [8] = '{0, 1, 3, 4, 5, 6, 7, 0};

  initial begin
    logic [DW-1:0] v;
    logic [24:0] row;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy_n", int'(busy_n), 1);
    chk("R1 sample_all", int'(sample_all), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    for (int r = 0; r < 9; r++) begin
      row = VEC[r];
      clear_log();
      do_write(row[24:22], row[21:18]);
      if (row[17]) begin
        chk($sformatf("R3 row %0d sample_all", r), int'(sample_all), 1);
        chk($sformatf("R3 row %0d busy_n", r), int'(busy_n), 0);
        @(negedge clk);
        chk($sformatf("R3 row %0d sample_all once", r), int'(sample_all), 0);
        wait_idle();
        chk($sformatf("R4/R5 row %0d request mask", r), int'(log_mask), int'(row[16:9]));
        chk($sformatf("R7/R8 row %0d diff mask", r), int'(log_dmask), int'(row[8:1]));
        chk($sformatf("R7 row %0d bipolar", r), int'(log_bip), int'(row[0]));
        chk($sformatf("R4 row %0d ascending", r), int'(order_bad), 0);
      end else begin
        for (int k = 0; k < 3; k++) begin
          chk($sformatf("R2 row %0d busy_n stays high", r), int'(busy_n), 1);
          @(negedge clk);
        end
        chk($sformatf("R2 row %0d no request", r), log_cnt, 0);
      end
    end

    // R11: read list after all-channel run with pair 1 differential (ch3)
    for (int k = 0; k < 8; k++) begin
      do_read(v);
      chk($sformatf("R11 read %0d data", k), int'(v), int'(exp_ram[RD_ORDER[k]]));
    end

    // R5/R11: single-channel run on ch6, then reads step 6,7,0
    clear_log();
    do_write(3'd6, 4'b0100);
    wait_idle();
    chk("R5 single ch6 mask", int'(log_mask), 8'h40);
    for (int k = 0; k < 3; k++) begin
      do_read(v);
      chk($sformatf("R11 single read %0d", k), int'(v), int'(exp_ram[(6 + k) % 8]));
    end

    // R12: inhibited write moves read pointer to ch3
    do_write(3'd3, 4'b1000);
    chk("R12 no start", int'(busy_n), 1);
    do_read(v);
    chk("R12 read at written address", int'(v), int'(exp_ram[3]));

    // R9: writes under power-down are ignored (pointer should now be 4)
    clear_log();
    pd = 1'b1;
    do_write(3'd7, 4'b1000);
    do_write(3'd1, 4'b0000);
    chk("R9 no start busy_n", int'(busy_n), 1);
    chk("R9 no sample", int'(sample_all), 0);
    chk("R9 no request", log_cnt, 0);
    pd = 1'b0;
    do_read(v);
    chk("R9 read pointer kept", int'(v), int'(exp_ram[4]));

    // R10: writes during a run are ignored
    clear_log();
    do_write(3'd0, 4'b0000);
    do_write(3'd6, 4'b1100);
    do_write(3'd2, 4'b0100);
    chk("R10 still busy during writes", int'(busy_n), 0);
    wait_idle();
    chk("R10 run mask unchanged", int'(log_mask), 8'hFB);
    repeat (10) @(negedge clk);
    chk("R10 no extra run", int'(busy_n), 1);
    chk("R10 request count", log_cnt, 7);
    do_read(v);
    chk("R10 read starts at ch0", int'(v), int'(exp_ram[0]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule